// File: doc/BRIEF.md
# Stage-Based Operand Interlock Scoreboard

This block decides, cycle by cycle, whether the instruction waiting at the issue point may issue or must stall. It does not model register contents or forwarding multiplexers. The only timing data it uses is the pipeline stage attached to each operand. A source carries the stage in which it is read. The destination carries the stage in which its result is written. Forwarding legality follows from stage arithmetic alone; no table of forwarding paths is consulted.

Every producer that has issued and whose result is not yet available is held in a small table. Each entry stores the register index and the number of cycles left until the result exists. The counts fall by one every clock, so a stall always clears on its own. A consumer stalls while any of its sources has more cycles left than the stage in which that source is read. When two in-flight producers name the same register, the younger one replaces the older, so the younger one decides readiness.

The stall output is combinational from the table registers and the presented operands. The issue stage holds its operands while stall is high and repeats them until the instruction is accepted.

Top module: `operand_interlock_sb`

## Requirements
- R1: Out of reset the table is empty, so any instruction issues without a stall, whatever its sources.
- R2: A read stage of 0xFF marks an operand as no source, and that operand never causes a stall. A write stage of 0xFF marks no destination and allocates no entry.
- R3: A producer with write stage W issues in cycle t. A consumer presented in cycle t+k (k ≥ 1) that reads the same register at stage R stalls exactly while W − k > R. A stalled instruction allocates nothing.
- R4: Back-to-back dependent scalar adds (write stage 4, read stage 4) never stall.
- R5: For a vector consumer reading at stage 10, the stall cycles directly after the producer are: 0 after write stage 11, 1 after write stage 12, and 2 after write stage 13. The last case includes a multiply-accumulate that reads its own accumulator at stage 10.
- R6: With two sources, the instruction stalls until both are ready. The stall length is set by the slower source.
- R7: Counts keep falling during idle cycles and stall cycles, so a gap after a producer shortens the stall by the length of the gap.
- R8: When a second producer names a register that already has an entry, it replaces that entry. Readiness then follows the younger producer only, whether it is slower or faster than the older one.
- R9: A destination index of 0 allocates no entry and takes no table space.
- R10: A write stage of 0 or 1 allocates no entry, because the result is available before any later consumer reads it.
- R11: The table holds DEPTH entries (default 8). A producer that needs a new entry stalls while all entries are busy. An entry frees in the cycle after its count reaches zero. A producer whose register already has an entry reuses it and does not stall on a full table.
- R12: Stall is low in every cycle in which no instruction is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears the table |
| issue_valid | input | 1 | An instruction is presented this cycle |
| src_a_idx | input | IDX_W | Register index of the first source |
| src_a_rd | input | 8 | Read stage of the first source; 0xFF means not a source |
| src_b_idx | input | IDX_W | Register index of the second source |
| src_b_rd | input | 8 | Read stage of the second source; 0xFF means not a source |
| dst_idx | input | IDX_W | Destination register index; 0 means no tracked result |
| dst_wr | input | 8 | Write stage of the destination; 0xFF means not a destination |
| stall | output | 1 | The presented instruction must be held this cycle |

## Verification
Three events can fall in the same cycle: the table is full, a new producer names a register that already has an entry, and the oldest entry is counting toward retirement. The bench fills every entry with long-latency producers. One producer in the fill has destination 0 to show that it takes no space. The bench then re-targets a register already in the table and must see no stall. Next it presents a producer for a new register, which must stall for exactly the number of cycles until the oldest entry frees. A second pairing puts two sources with different readiness into one instruction; the stall count must match the slower source.

// File: rtl/opsb_pkg.sv
package opsb_pkg;

  localparam int STAGE_W = 8;

  typedef logic [STAGE_W-1:0] stage_t;

  // Marker for "operand is not a source / not a destination".
  localparam stage_t STAGE_NONE = 8'hFF;

  // A producer whose result lands at stage 0 or 1 is already available
  // to any instruction issued later, so it never needs tracking.
  localparam stage_t STAGE_TRACK_MIN = 8'd2;

  function automatic logic stage_is_live(input stage_t s);
    return s != STAGE_NONE;
  endfunction

endpackage

// File: rtl/sb_entry_table.sv
module sb_entry_table
  import opsb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = 5,
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [SLOT_W-1:0]           wslot,
  input  logic [IDX_W-1:0]            widx,
  input  stage_t                      wcnt,
  output logic [DEPTH-1:0]            ent_vld,
  output logic [DEPTH-1:0][IDX_W-1:0] ent_idx,
  output logic [DEPTH-1:0][STAGE_W-1:0] ent_cnt
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic hit;
    assign hit = we && (wslot == SLOT_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        ent_vld[i] <= 1'b0;
        ent_idx[i] <= '0;
        ent_cnt[i] <= '0;
      end else if (hit) begin
        ent_vld[i] <= 1'b1;
        ent_idx[i] <= widx;
        ent_cnt[i] <= wcnt;
      end else if (ent_vld[i]) begin
        ent_cnt[i] <= ent_cnt[i] - 1'b1;
        ent_vld[i] <= (ent_cnt[i] != 8'd1);
      end
    end

    // R3: a live entry always has cycles left to count
    p_live_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
      ent_vld[i] |-> (ent_cnt[i] != 8'd0));

    // R7: untouched entries fall by exactly one each clock
    p_count_down_r7: assert property (@(posedge clk) disable iff (rst)
      (ent_vld[i] && !hit && ent_cnt[i] > 8'd1)
      |=> (ent_vld[i] && ent_cnt[i] == $past(ent_cnt[i]) - 8'd1));

    // R11: an entry at its last count frees on the next clock
    p_retire_r11: assert property (@(posedge clk) disable iff (rst)
      (ent_vld[i] && !hit && ent_cnt[i] == 8'd1) |=> !ent_vld[i]);

    // R9: register 0 never owns an entry
    p_no_reg0_r9: assert property (@(posedge clk) disable iff (rst)
      ent_vld[i] |-> (ent_idx[i] != '0));
  end

endmodule

// File: rtl/sb_src_check.sv
module sb_src_check
  import opsb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [DEPTH-1:0]              ent_vld,
  input  logic [DEPTH-1:0][IDX_W-1:0]   ent_idx,
  input  logic [DEPTH-1:0][STAGE_W-1:0] ent_cnt,
  input  logic [IDX_W-1:0]              src_idx,
  input  stage_t                        rd_stage,
  output logic                          hazard
);

  logic [DEPTH-1:0] match;
  stage_t           remain;

  always_comb begin
    remain = '0;
    for (int i = 0; i < DEPTH; i++) begin
      match[i] = ent_vld[i] && (ent_idx[i] == src_idx);
      if (match[i]) remain = remain | ent_cnt[i];
    end
    hazard = stage_is_live(rd_stage) && (remain > rd_stage);
  end

  // R8: replacement keeps at most one owner per register
  p_one_owner_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));

endmodule

// File: rtl/sb_slot_pick.sv
module sb_slot_pick
  import opsb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = 5,
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0]            ent_vld,
  input  logic [DEPTH-1:0][IDX_W-1:0] ent_idx,
  input  logic [IDX_W-1:0]            dst_idx,
  output logic [SLOT_W-1:0]           slot,
  output logic                        slot_ok
);

  logic              hit_any, free_any;
  logic [SLOT_W-1:0] hit_slot, free_slot;

  always_comb begin
    hit_any   = 1'b0;
    free_any  = 1'b0;
    hit_slot  = '0;
    free_slot = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (ent_vld[i] && ent_idx[i] == dst_idx) begin
        hit_any  = 1'b1;
        hit_slot = SLOT_W'(i);
      end
      if (!ent_vld[i]) begin
        free_any  = 1'b1;
        free_slot = SLOT_W'(i);
      end
    end
    slot    = hit_any ? hit_slot : free_slot;
    slot_ok = hit_any || free_any;
  end

endmodule

// File: rtl/operand_interlock_sb.sv
module operand_interlock_sb
  import opsb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DEPTH    = 8,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int SLOT_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_valid,
  input  logic [IDX_W-1:0] src_a_idx,
  input  logic [7:0]       src_a_rd,
  input  logic [IDX_W-1:0] src_b_idx,
  input  logic [7:0]       src_b_rd,
  input  logic [IDX_W-1:0] dst_idx,
  input  logic [7:0]       dst_wr,
  output logic             stall
);

  logic [DEPTH-1:0]              ent_vld;
  logic [DEPTH-1:0][IDX_W-1:0]   ent_idx;
  logic [DEPTH-1:0][STAGE_W-1:0] ent_cnt;

  logic [1:0]        src_haz;
  logic [SLOT_W-1:0] slot;
  logic              slot_ok;
  logic              needs_entry;
  logic              alloc_we;

  // Two source ports share one checker shape.
  logic [1:0][IDX_W-1:0] src_idx_v;
  stage_t [1:0]          src_rd_v;
  assign src_idx_v = {src_b_idx, src_a_idx};
  assign src_rd_v  = {src_b_rd, src_a_rd};

  for (genvar s = 0; s < 2; s++) begin : g_src
    sb_src_check #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
      .clk      (clk),
      .rst      (rst),
      .ent_vld  (ent_vld),
      .ent_idx  (ent_idx),
      .ent_cnt  (ent_cnt),
      .src_idx  (src_idx_v[s]),
      .rd_stage (src_rd_v[s]),
      .hazard   (src_haz[s])
    );
  end

  sb_slot_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick (
    .ent_vld (ent_vld),
    .ent_idx (ent_idx),
    .dst_idx (dst_idx),
    .slot    (slot),
    .slot_ok (slot_ok)
  );

  assign needs_entry = (dst_idx != '0) && stage_is_live(dst_wr)
                       && (dst_wr >= STAGE_TRACK_MIN);

  assign stall    = issue_valid && ((|src_haz) || (needs_entry && !slot_ok));
  assign alloc_we = issue_valid && !stall && needs_entry;

  sb_entry_table #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_tab (
    .clk     (clk),
    .rst     (rst),
    .we      (alloc_we),
    .wslot   (slot),
    .widx    (dst_idx),
    .wcnt    (dst_wr - 8'd1),
    .ent_vld (ent_vld),
    .ent_idx (ent_idx),
    .ent_cnt (ent_cnt)
  );

  // R11: whenever the table has room, the picker offers a slot
  p_room_gives_slot_r11: assert property (@(posedge clk) disable iff (rst)
    ($countones(ent_vld) < DEPTH) |-> slot_ok);

  // R11: occupancy grows by at most one entry per clock
  p_grow_one_r11: assert property (@(posedge clk) disable iff (rst)
    $countones(ent_vld) <= $past($countones(ent_vld)) + 1);

  // R1: the clock after reset the table holds nothing
  p_empty_after_reset_r1: assert property (@(posedge clk)
    $fell(rst) |-> (ent_vld == '0));

endmodule

// File: tb/tb_operand_interlock_sb.sv
module tb_operand_interlock_sb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       issue_valid = 1'b0;
  logic [4:0] src_a_idx = '0, src_b_idx = '0, dst_idx = '0;
  logic [7:0] src_a_rd = 8'hFF, src_b_rd = 8'hFF, dst_wr = 8'hFF;
  logic       stall;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  operand_interlock_sb #(.NUM_REGS(32), .DEPTH(8)) dut (
    .clk(clk), .rst(rst), .issue_valid(issue_valid),
    .src_a_idx(src_a_idx), .src_a_rd(src_a_rd),
    .src_b_idx(src_b_idx), .src_b_rd(src_b_rd),
    .dst_idx(dst_idx), .dst_wr(dst_wr), .stall(stall)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Present one instruction, hold it until accepted, return stall cycles.
  task automatic send(input logic [4:0] sa, input logic [7:0] ra,
                      input logic [4:0] sb, input logic [7:0] rb,
                      input logic [4:0] d,  input logic [7:0] w,
                      output int stalls);
    issue_valid = 1'b1;
    src_a_idx = sa; src_a_rd = ra;
    src_b_idx = sb; src_b_rd = rb;
    dst_idx = d;    dst_wr = w;
    stalls = 0;
    while (1) begin
      @(negedge clk);
      if (stall && stalls < 500) begin
        stalls++;
        @(posedge clk); #1;
      end else begin
        @(posedge clk); #1;
        break;
      end
    end
    issue_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic t_reset();
    int s;
    @(negedge clk);
    check("R12 idle stall", int'(stall), 0);
    send(5'd3, 8'd0, 5'd31, 8'd0, 5'd0, 8'hFF, s);
    check("R1 fresh issue", s, 0);
  endtask

  task automatic t_scalar();
    int s;
    send(5'd0, 8'hFF, 5'd0, 8'hFF, 5'd1, 8'd4, s);
    check("R4 first add", s, 0);
    send(5'd1, 8'd4, 5'd0, 8'hFF, 5'd2, 8'd4, s);
    check("R4 dependent add", s, 0);
    send(5'd2, 8'd4, 5'd1, 8'd4, 5'd3, 8'd4, s);
    check("R4 second dependent add", s, 0);
    idle(16);
  endtask

  task automatic t_vector();
    int s;
    send(5'd0, 8'hFF, 5'd0, 8'hFF, 5'd3, 8'd11, s);
    send(5'd3, 8'd10, 5'd0, 8'hFF, 5'd0, 8'hFF, s);
    check("R5 write 11 read 10", s, 0);
    idle(16);
    send(5'd0, 8'hFF, 5'd0, 8'hFF, 5'd4, 8'd12, s);
    send(5'd4, 8'd10, 5'd0, 8'hFF, 5'd0, 8'hFF, s);
    check("R5 write 12 read 10", s, 1);
    idle(16);
    send(5'd0, 8'hFF, 5'd0, 8'hFF, 5'd5, 8'd13, s);
    send(5'd5, 8'd10, 5'd0, 8'hFF, 5'd0, 8'hFF, s);
    check("R5 write 13 read 10", s, 2);
    idle(16);
    send(5'd6, 8'd10, 5'd0, 8'hFF, 5'd6, 8'd13, s);
    send(5'd6, 8'd10, 5'd0, 8'hFF, 5'd6, 8'd13, s);
    check("R5 accumulate chain", s, 2);
    idle(16);
  endtask

  task automatic t_cross();
    int s;
    send(5'd0, 8'hFF, 5'd0, 8'hFF, 5'd7, 8'd12, s);
    send(5'd7, 8'd4, 5'd0, 8'hFF, 5'd0, 8'hFF, s);
    check("R3 scalar reads vector result", s, 7);
    idle(16);
    send(5'd0, 8'hFF, 5'd0, 8'hFF, 5'd7, 8'd12, s);
    idle(3);
    send(5'd7, 8'd4, 5'd0, 8'hFF, 5'd0, 8'hFF, s);
    check("R7 gap shortens stall", s, 4);
    idle(16);
  endtask

  task automatic t_two_src();
    int s;
    send(5'd0, 8'hFF, 5'd0, 8'hFF, 5'd8, 8'd13, s);
    send(5'd0, 8'hFF, 5'd0, 8'hFF, 5'd9, 8'd4, s);
    send(5'd9, 8'd4, 5'd8, 8'd10, 5'd0, 8'hFF, s);
    check("R6 slower second source", s, 1);
    idle(16);
    send(5'd0, 8'hFF, 5'd0, 8'hFF, 5'd8, 8'd12, s);
    send(5'd0, 8'hFF, 5'd0, 8'hFF, 5'd9, 8'd13, s);
    send(5'd8, 8'd4, 5'd9, 8'd10, 5'd0, 8'hFF, s);
    check("R6 slower first source", s, 6);
    idle(16);
  endtask

  task automatic t_none();
    int s;
    send(5'd0, 8'hFF, 5'd0, 8'hFF, 5'd10, 8'd13, s);
    send(5'd10, 8'hFF, 5'd10, 8'hFF, 5'd0, 8'hFF, s);
    check("R2 not-a-source ignored", s, 0);
    idle(16);
    send(5'd0, 8'hFF, 5'd0, 8'hFF, 5'd11, 8'hFF, s);
    send(5'd11, 8'd0, 5'd0, 8'hFF, 5'd0, 8'hFF, s);
    check("R2 not-a-destination", s, 0);
    send(5'd0, 8'hFF, 5'd0, 8'hFF, 5'd12, 8'd1, s);
    send(5'd12, 8'd0, 5'd0, 8'hFF, 5'd0, 8'hFF, s);
    check("R10 write stage 1", s, 0);
    idle(16);
  endtask

  task automatic t_newest();
    int s;
    send(5'd0, 8'hFF, 5'd0, 8'hFF, 5'd5, 8'd13, s);
    send(5'd0, 8'hFF, 5'd0, 8'hFF, 5'd5, 8'd4, s);
    send(5'd5, 8'd4, 5'd0, 8'hFF, 5'd0, 8'hFF, s);
    check("R8 younger fast producer decides", s, 0);
    idle(16);
    send(5'd0, 8'hFF, 5'd0, 8'hFF, 5'd5, 8'd4, s);
    send(5'd0, 8'hFF, 5'd0, 8'hFF, 5'd5, 8'd13, s);
    send(5'd5, 8'd4, 5'd0, 8'hFF, 5'd0, 8'hFF, s);
    check("R8 younger slow producer decides", s, 8);
    idle(16);
  endtask

  task automatic t_full();
    int s;
    int tot = 0;
    for (int r = 1; r <= 7; r++) begin
      send(5'd0, 8'hFF, 5'd0, 8'hFF, 5'(r), 8'd13, s);
      tot += s;
    end
    check("R11 seven fills", tot, 0);
    send(5'd0, 8'hFF, 5'd0, 8'hFF, 5'd0, 8'd13, s);
    check("R9 dst 0 accepted", s, 0);
    send(5'd0, 8'hFF, 5'd0, 8'hFF, 5'd8, 8'd13, s);
    check("R9 eighth entry still free", s, 0);
    send(5'd0, 8'hFF, 5'd0, 8'hFF, 5'd3, 8'd13, s);
    check("R11 reuse on full table", s, 0);
    send(5'd0, 8'hFF, 5'd0, 8'hFF, 5'd9, 8'd13, s);
    check("R11 new register waits for retire", s, 3);
    idle(20);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_scalar();
    t_vector();
    t_cross();
    t_two_src();
    t_none();
    t_newest();
    t_full();
    @(negedge clk);
    check("R12 idle after run", int'(stall), 0);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

endmodule